// File: doc/BRIEF.md
# Exception and Interrupt Priority Selector

This block decides, at every instruction boundary of a simple 16-bit processor model, which pending event the core enters next. The core pulses `retire` once for each instruction that completes. On that pulse the block weighs four kinds of event:

- synchronous fault pulses from the instruction that just finished (undefined opcode, general protection);
- a single-step trap armed by the trap flag;
- a latched numeric coprocessor error;
- a level-sensitive maskable external interrupt that brings its own vector number.

It then issues at most one 8-bit vector with a one-cycle `take` strobe. Requests it does not service stay pending for later boundaries.

Single-step outranks every asynchronous request. When a step trap and an external interrupt are both pending, the step trap goes first. The external handler's first instruction is therefore never stepped. The block also refuses to arm a step trap at the boundary that follows an external or coprocessor entry. Handlers entered through a software INT (flagged by `softEntry`) or through a fault are still stepped. `flagClear` tells the flags logic to drop the trap and interrupt-enable flags while the vector is fetched.

Top module: `evt_priority_sel`

## Requirements
- R1: After reset `take`, `flagClear` and `vector` are 0, and no event is pending: a `retire` with every request low issues nothing.
- R2: An undefined-opcode fault (pulse on `udFault`, or pending from an earlier pulse) is issued as vector 6 ahead of every other event.
- R3: A general-protection fault is issued as vector 13. It outranks the step trap and all asynchronous requests, and ranks below the undefined-opcode fault.
- R4: A `retire` with `trapFlag`=1 arms a step trap, issued as vector 1. It outranks the coprocessor error and the external interrupt.
- R5: A coprocessor error request (`npxErrReq` pulse, latched) is issued as vector 16. It outranks the external interrupt.
- R6: The external interrupt is issued with the vector on `extVector`, only when `extReq`=1 and `intEnable`=1 at the `retire`. With `intEnable`=0 it has no effect on `take`.
- R7: A vector appears only in the cycle after a `retire` and lasts one cycle. At most one vector is issued per `retire`, and `flagClear` pulses together with `take`.
- R8: Unserviced fault, step and coprocessor requests stay pending. They are issued at later retires in the order undefined-opcode, protection, step, coprocessor. An unserviced external request is not held by the block.
- R9: At the first `retire` after an external or coprocessor vector, `trapFlag`=1 arms no step trap unless `softEntry`=1 at that `retire`. A fault-entered handler keeps a pending step trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One-cycle pulse at each instruction boundary |
| trapFlag | input | 1 | Single-step flag of the retiring instruction |
| softEntry | input | 1 | Retiring instruction entered a handler by software INT or fault |
| intEnable | input | 1 | Maskable interrupt enable flag |
| extReq | input | 1 | External interrupt request level |
| extVector | input | 8 | Vector supplied with the external request |
| npxErrReq | input | 1 | Coprocessor error request pulse |
| udFault | input | 1 | Undefined-opcode fault pulse |
| gpFault | input | 1 | General-protection fault pulse |
| take | output | 1 | One-cycle strobe: vector valid |
| vector | output | 8 | Vector number to enter |
| flagClear | output | 1 | Clear trap and interrupt-enable flags for the entry |

## Verification
Every result is registered once. The vector and strobe for a `retire` are due in the cycle that starts at the clock edge capturing that `retire`, and they are gone one edge later. The bench drives each `retire` on a falling edge. It lowers the strobe at the next falling edge and samples `take` and `vector` there, which falls inside the one cycle the result is due. Fault pulses that arrive without a `retire` are sampled on each idle falling edge to confirm no vector leaks out early. Pending events are then drained one `retire` at a time, and the issue order is checked against the ranking.

// File: rtl/evt_sel_pkg.sv
package evt_sel_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_UD   = 3'd1,
    SRC_GP   = 3'd2,
    SRC_STEP = 3'd3,
    SRC_NPX  = 3'd4,
    SRC_EXT  = 3'd5
  } srcKind_e;

  // index of each latched request inside the datapath pending array
  localparam int LATCH_UD  = 0;
  localparam int LATCH_GP  = 1;
  localparam int LATCH_NPX = 2;
  localparam int LATCH_CNT = 3;

  typedef struct packed {
    logic                 issue;
    srcKind_e             kind;
    logic [LATCH_CNT-1:0] clrLatch;
    logic                 clrStep;
    logic                 armStep;
  } ctrlStrobe_t;

endpackage

// File: rtl/evt_sel_ctrl.sv
module evt_sel_ctrl
  import evt_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retire,
  input  logic        trapFlag,
  input  logic        softEntry,
  input  logic        intEnable,
  input  logic        extReq,
  input  logic        udNow,
  input  logic        gpNow,
  input  logic        stepNow,
  input  logic        npxNow,
  output ctrlStrobe_t ctl
);

  logic asyncEntryQ;
  logic armOk;
  logic stepCand;
  logic extCand;

  // stepping is not armed on the boundary right after an async entry,
  // unless that boundary itself is a software or fault entry
  assign armOk    = trapFlag & (~asyncEntryQ | softEntry);
  assign stepCand = stepNow | armOk;
  assign extCand  = extReq & intEnable;

  always_comb begin
    ctl          = '0;
    ctl.kind     = SRC_NONE;
    ctl.armStep  = retire & armOk;
    if (retire) begin
      if (udNow) begin
        ctl.issue                 = 1'b1;
        ctl.kind                  = SRC_UD;
        ctl.clrLatch[LATCH_UD]    = 1'b1;
      end else if (gpNow) begin
        ctl.issue                 = 1'b1;
        ctl.kind                  = SRC_GP;
        ctl.clrLatch[LATCH_GP]    = 1'b1;
      end else if (stepCand) begin
        ctl.issue                 = 1'b1;
        ctl.kind                  = SRC_STEP;
        ctl.clrStep               = 1'b1;
      end else if (npxNow) begin
        ctl.issue                 = 1'b1;
        ctl.kind                  = SRC_NPX;
        ctl.clrLatch[LATCH_NPX]   = 1'b1;
      end else if (extCand) begin
        ctl.issue                 = 1'b1;
        ctl.kind                  = SRC_EXT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asyncEntryQ <= 1'b0;
    end else if (retire) begin
      asyncEntryQ <= ctl.issue & ((ctl.kind == SRC_NPX) | (ctl.kind == SRC_EXT));
    end
  end

  // R7: a single source is cleared per boundary
  assert_one_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.clrLatch, ctl.clrStep}));

  // R2: a present undefined-opcode fault is always the chosen source
  assert_ud_chosen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && udNow) |-> (ctl.kind == SRC_UD));

  // R6: masked external request never chosen
  assert_ext_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !intEnable) |-> (ctl.kind != SRC_EXT));

endmodule

// File: rtl/evt_sel_path.sv
module evt_sel_path
  import evt_sel_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int UD_VEC   = 6,
  parameter int GP_VEC   = 13,
  parameter int STEP_VEC = 1,
  parameter int NPX_VEC  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             udFault,
  input  logic             gpFault,
  input  logic             npxErrReq,
  input  logic [VEC_W-1:0] extVector,
  input  ctrlStrobe_t      ctl,
  output logic             udNow,
  output logic             gpNow,
  output logic             stepNow,
  output logic             npxNow,
  output logic             takeQ,
  output logic [VEC_W-1:0] vecQ
);

  localparam logic [VEC_W-1:0] UD_CODE   = VEC_W'(UD_VEC);
  localparam logic [VEC_W-1:0] GP_CODE   = VEC_W'(GP_VEC);
  localparam logic [VEC_W-1:0] STEP_CODE = VEC_W'(STEP_VEC);
  localparam logic [VEC_W-1:0] NPX_CODE  = VEC_W'(NPX_VEC);

  logic [LATCH_CNT-1:0] reqIn;
  logic [LATCH_CNT-1:0] pendQ;
  logic [LATCH_CNT-1:0] nowVec;
  logic                 stepPendQ;
  logic [VEC_W-1:0]     vecNext;

  assign reqIn[LATCH_UD]  = udFault;
  assign reqIn[LATCH_GP]  = gpFault;
  assign reqIn[LATCH_NPX] = npxErrReq;

  for (genvar g = 0; g < LATCH_CNT; g++) begin : gen_latch
    assign nowVec[g] = pendQ[g] | reqIn[g];
    always_ff @(posedge clk) begin
      if (!rst_n) pendQ[g] <= 1'b0;
      else        pendQ[g] <= nowVec[g] & ~ctl.clrLatch[g];
    end
  end

  assign udNow   = nowVec[LATCH_UD];
  assign gpNow   = nowVec[LATCH_GP];
  assign npxNow  = nowVec[LATCH_NPX];
  assign stepNow = stepPendQ;

  always_ff @(posedge clk) begin
    if (!rst_n) stepPendQ <= 1'b0;
    else        stepPendQ <= (stepPendQ | ctl.armStep) & ~ctl.clrStep;
  end

  always_comb begin
    case (ctl.kind)
      SRC_UD:   vecNext = UD_CODE;
      SRC_GP:   vecNext = GP_CODE;
      SRC_STEP: vecNext = STEP_CODE;
      SRC_NPX:  vecNext = NPX_CODE;
      SRC_EXT:  vecNext = extVector;
      default:  vecNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      takeQ <= 1'b0;
      vecQ  <= '0;
    end else begin
      takeQ <= ctl.issue;
      if (ctl.issue) vecQ <= vecNext;
    end
  end

  // R8: a latched fault survives a boundary that does not serve it
  assert_ud_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ[LATCH_UD] && !ctl.issue) |=> pendQ[LATCH_UD]);

  assert_npx_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ[LATCH_NPX] && ctl.kind != SRC_NPX) |=> pendQ[LATCH_NPX]);

  assert_step_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stepPendQ && ctl.kind != SRC_STEP) |=> stepPendQ);

endmodule

// File: rtl/evt_priority_sel.sv
module evt_priority_sel
  import evt_sel_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int UD_VEC   = 6,
  parameter int GP_VEC   = 13,
  parameter int STEP_VEC = 1,
  parameter int NPX_VEC  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             trapFlag,
  input  logic             softEntry,
  input  logic             intEnable,
  input  logic             extReq,
  input  logic [VEC_W-1:0] extVector,
  input  logic             npxErrReq,
  input  logic             udFault,
  input  logic             gpFault,
  output logic             take,
  output logic [VEC_W-1:0] vector,
  output logic             flagClear
);

  ctrlStrobe_t ctl;
  logic udNow, gpNow, stepNow, npxNow;

  evt_sel_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .trapFlag  (trapFlag),
    .softEntry (softEntry),
    .intEnable (intEnable),
    .extReq    (extReq),
    .udNow     (udNow),
    .gpNow     (gpNow),
    .stepNow   (stepNow),
    .npxNow    (npxNow),
    .ctl       (ctl)
  );

  evt_sel_path #(
    .VEC_W    (VEC_W),
    .UD_VEC   (UD_VEC),
    .GP_VEC   (GP_VEC),
    .STEP_VEC (STEP_VEC),
    .NPX_VEC  (NPX_VEC)
  ) path_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .udFault   (udFault),
    .gpFault   (gpFault),
    .npxErrReq (npxErrReq),
    .extVector (extVector),
    .ctl       (ctl),
    .udNow     (udNow),
    .gpNow     (gpNow),
    .stepNow   (stepNow),
    .npxNow    (npxNow),
    .takeQ     (take),
    .vecQ      (vector)
  );

  assign flagClear = take;

  // R7: nothing is issued without a boundary
  assert_no_idle_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> !take);

  // R2: undefined opcode yields its vector on the next cycle
  assert_ud_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && udNow) |=> (take && vector == VEC_W'(UD_VEC)));

  // R3: protection fault beats everything but the undefined opcode
  assert_gp_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && gpNow && !udNow) |=> (take && vector == VEC_W'(GP_VEC)));

  // R4: a pending step trap beats the asynchronous requests
  assert_step_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && stepNow && !udNow && !gpNow) |=> (take && vector == VEC_W'(STEP_VEC)));

  // R5: coprocessor error beats the external interrupt
  assert_npx_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && npxNow && !udNow && !gpNow && !stepNow && !trapFlag)
      |=> (take && vector == VEC_W'(NPX_VEC)));

  // R6: with interrupts disabled and nothing else present, no vector
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !intEnable && !udNow && !gpNow && !stepNow && !npxNow && !trapFlag)
      |=> !take);

endmodule

// File: tb/evt_priority_sel_tb_top.sv
`timescale 1ns/1ps
module evt_priority_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       retire, trapFlag, softEntry, intEnable, extReq;
  logic [7:0] extVector;
  logic       npxErrReq, udFault, gpFault;
  logic       take, flagClear;
  logic [7:0] vector;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  evt_priority_sel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .trapFlag  (trapFlag),
    .softEntry (softEntry),
    .intEnable (intEnable),
    .extReq    (extReq),
    .extVector (extVector),
    .npxErrReq (npxErrReq),
    .udFault   (udFault),
    .gpFault   (gpFault),
    .take      (take),
    .vector    (vector),
    .flagClear (flagClear)
  );

  task automatic check(input string req, input logic expTake, input logic [7:0] expVec);
    testsRun++;
    if (take !== expTake || flagClear !== expTake || (expTake && vector !== expVec)) begin
      testsFailed++;
      $display("FAIL %s: take=%0b flagClear=%0b vector=%0d, expected take=%0b vector=%0d",
               req, take, flagClear, vector, expTake, expVec);
    end
  endtask

  task automatic clearInputs();
    retire = 0; trapFlag = 0; softEntry = 0; intEnable = 0; extReq = 0;
    extVector = 8'h00; npxErrReq = 0; udFault = 0; gpFault = 0;
  endtask

  // one boundary: drive on a falling edge, sample at the next falling edge
  task automatic boundary(input logic ud, input logic gp, input logic tf, input logic sw,
                          input logic npx, input logic ext, input logic ie,
                          input logic [7:0] ev, input logic expTake,
                          input logic [7:0] expVec, input string req);
    @(negedge clk);
    retire = 1; udFault = ud; gpFault = gp; trapFlag = tf; softEntry = sw;
    npxErrReq = npx; extReq = ext; intEnable = ie; extVector = ev;
    @(negedge clk);
    clearInputs();
    check(req, expTake, expVec);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    clearInputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    testsRun++;
    if (take !== 0 || flagClear !== 0 || vector !== 8'd0) begin
      testsFailed++;
      $display("FAIL R1: take=%0b vector=%0d, expected take=0 vector=0", take, vector);
    end
    boundary(0,0,0,0,0,0,0,8'h00, 0, 8'd0, "R1 empty after reset");

    // sweep every combination of the six request inputs
    for (int c = 0; c < 64; c++) begin
      logic ud, gp, tf, npx, ext, ie;
      logic [7:0] ev;
      logic [7:0] firstVec;
      logic firstTake;
      logic remUd, remGp, remStep, remNpx;
      string tag;
      ud = c[0]; gp = c[1]; tf = c[2]; npx = c[3]; ext = c[4]; ie = c[5];
      ev = 8'h20 + 8'(c * 3);
      remUd = ud; remGp = gp; remStep = tf; remNpx = npx;
      firstTake = 1;
      if (ud)              begin firstVec = 8'd6;  remUd = 0;   tag = "R2 sweep first"; end
      else if (gp)         begin firstVec = 8'd13; remGp = 0;   tag = "R3 sweep first"; end
      else if (tf)         begin firstVec = 8'd1;  remStep = 0; tag = "R4 sweep first"; end
      else if (npx)        begin firstVec = 8'd16; remNpx = 0;  tag = "R5 sweep first"; end
      else if (ext && ie)  begin firstVec = ev;                 tag = "R6 sweep first"; end
      else                 begin firstVec = 8'd0; firstTake = 0; tag = "R6 sweep none"; end
      boundary(ud, gp, tf, 0, npx, ext, ie, ev, firstTake, firstVec, tag);
      // R8: drain the leftovers in rank order
      if (remUd)   boundary(0,0,0,0,0,0,0,8'h00, 1, 8'd6,  "R8 drain ud");
      if (remGp)   boundary(0,0,0,0,0,0,0,8'h00, 1, 8'd13, "R8 drain gp");
      if (remStep) boundary(0,0,0,0,0,0,0,8'h00, 1, 8'd1,  "R8 drain step");
      if (remNpx)  boundary(0,0,0,0,0,0,0,8'h00, 1, 8'd16, "R8 drain npx");
      boundary(0,0,0,0,0,0,0,8'h00, 0, 8'd0, "R7 one vector per boundary, then empty");
    end

    // R7: a fault pulse with no boundary produces no vector
    @(negedge clk);
    udFault = 1;
    @(negedge clk);
    udFault = 0;
    check("R7 no take without retire", 0, 8'd0);
    repeat (2) begin
      @(negedge clk);
      check("R7 idle stays quiet", 0, 8'd0);
    end
    boundary(0,0,0,0,0,1,1,8'h55, 1, 8'd6, "R8 latched fault served at later retire");

    // R7: take lasts exactly one cycle
    boundary(0,1,0,0,0,0,0,8'h00, 1, 8'd13, "R3 protection fault");
    @(negedge clk);
    check("R7 strobe single cycle", 0, 8'd0);

    // R6: masked external request leaves no trace
    boundary(0,0,0,0,0,1,0,8'h77, 0, 8'd0, "R6 masked request ignored");
    boundary(0,0,0,0,0,0,0,8'h00, 0, 8'd0, "R6 masked request not held");

    // R9: external entry, then the handler's first boundary is not stepped
    boundary(0,0,0,0,0,1,1,8'h40, 1, 8'h40, "R6 external vector");
    boundary(0,0,1,0,0,0,0,8'h00, 0, 8'd0, "R9 no step after external entry");
    boundary(0,0,0,0,0,0,0,8'h00, 0, 8'd0, "R9 step not left pending");
    // R9: software entry after external entry still steps
    boundary(0,0,0,0,0,1,1,8'h41, 1, 8'h41, "R6 external vector again");
    boundary(0,0,1,1,0,0,0,8'h00, 1, 8'd1, "R9 software entry stepped");
    // R9: coprocessor entry also suppresses stepping for one boundary
    boundary(0,0,0,0,1,0,0,8'h00, 1, 8'd16, "R5 coprocessor vector");
    boundary(0,0,1,0,0,0,0,8'h00, 0, 8'd0, "R9 no step after coprocessor entry");
    boundary(0,0,1,0,0,0,0,8'h00, 1, 8'd1, "R4 stepping resumes");
    // R9: fault entry keeps the step trap
    boundary(1,0,1,0,0,0,0,8'h00, 1, 8'd6, "R2 fault while stepping");
    boundary(0,0,0,0,0,1,1,8'h66, 1, 8'd1, "R9 fault handler stepped before external");
    boundary(0,0,0,0,0,1,1,8'h66, 1, 8'h66, "R6 external after step");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule